// File: doc/BRIEF.md
# Cascadable Four-Tap FIR Slice

The slice is a direct-form FIR filter with four taps on signed 18-bit samples and signed 18-bit coefficients. Two shift chains live inside it. The sample chain holds the four most recent accepted samples, with the newest sample in tap 0. The coefficient chain holds one coefficient per tap. Each tap's sample is multiplied by that tap's coefficient, and the four signed products are added into one registered 38-bit result.

The last register of the sample chain drives a cascade output. A select input can feed the first register of a slice from a cascade input in place of the local sample input. Slices can therefore be joined into one long delay line, and an external adder combines their outputs. Coefficients are loaded in one of two ways: serially, one per cycle, entering at tap 0 and moving toward tap 3; or all four at once from a parallel bus. A synchronous active-low reset clears the sample chain and the output pipeline. It leaves the coefficients untouched, so a filter can be flushed without being reprogrammed.

Top module: `fir4_slice`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the slice clears `y_out`, `y_valid` and every sample register, so `casc_out` also reads 0.
- R2: Each edge with `smp_valid` high shifts the sample chain by one tap: tap 0 takes the new sample, and `casc_out` shows the sample accepted four strobes earlier. An edge with `smp_valid` low leaves the chain and `casc_out` unchanged.
- R3: `casc_sel` chooses where tap 0 takes its sample when the chain shifts. A value of 0 selects `smp_in` and a value of 1 selects `casc_in`.
- R4: An edge with `coef_ld_en` high and `coef_par_ld` low performs a serial step. `coef_ser_in` becomes the tap 0 coefficient, and every other tap takes the coefficient its lower neighbour held before the edge.
- R5: An edge with `coef_ld_en` high and `coef_par_ld` high loads all four coefficients in that single edge. Tap k takes bits [18k+17:18k] of `coef_par_in`.
- R6: When a serial step and a parallel load are requested in the same edge, the parallel load wins and `coef_ser_in` is ignored.
- R7: While `coef_ld_en` is low, the coefficients do not change, whatever `coef_par_ld`, `coef_par_in` and `coef_ser_in` carry.
- R8: `y_out` is the two's-complement sum over k of (sample in tap k) × (coefficient of tap k). The sum is 38 bits wide and is registered.
- R9: For a sample accepted at edge E, the result appears with `y_valid` high after edge E+2. `y_valid` is high in a cycle only for that case.
- R10: A reset keeps the coefficients. After a reset, the filter runs with the coefficients that were loaded before it.
- R11: The full-scale extremes are summed exactly and do not wrap. Four products of (−131072)×(−131072) give 68719476736. Four products of 131071×(−131072) give −68718952448.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe; the sample chain shifts when high |
| smp_in | input | 18 | Local signed sample |
| casc_sel | input | 1 | Source of tap 0: 0 selects local, 1 selects cascade |
| casc_in | input | 18 | Sample from the previous slice's cascade output |
| casc_out | output | 18 | Last tap of the sample chain, for the next slice |
| coef_ld_en | input | 1 | Coefficient chain update enable |
| coef_par_ld | input | 1 | 1 selects parallel load, 0 selects serial step |
| coef_ser_in | input | 18 | Serial coefficient entering tap 0 |
| coef_par_in | input | 72 | Parallel coefficients; tap k in bits [18k+17:18k] |
| y_out | output | 38 | Registered signed sum of the four products |
| y_valid | output | 1 | Marks the result belonging to an accepted sample |

## Verification
The bench builds the slice with its default parameters: 18-bit samples and coefficients and four taps, which gives a 38-bit sum. With these widths, the most negative sample and coefficient can be driven directly, so the bench can show that a sum of four full-scale products needs the two growth bits and neither wraps nor loses its sign. With four taps, a single impulse walks through every coefficient in turn. It also fills the chain, so the cascade output shows the first sample after exactly four strobes.

// File: rtl/fir4_pkg.sv
// Package fir4_pkg
// Shared constants and helpers for the four-tap FIR slice.
// Assumes all arithmetic is two's complement.
package fir4_pkg;

    // Encoding of the tap 0 source select
    localparam logic SRC_LOCAL   = 1'b0;
    localparam logic SRC_CASCADE = 1'b1;

    // Guard bits needed to add `taps` products without overflow
    function automatic int grow_bits(input int taps);
        return (taps <= 1) ? 1 : $clog2(taps);
    endfunction

endpackage

// File: rtl/fir4_data_chain.sv
// Module fir4_data_chain
// Sample delay line of N registers. Stage 0 takes either the local or the
// cascade sample, and every stage shifts only on `adv`. The last stage is
// exported as the cascade tail.
// Assumes a synchronous active-low reset that clears every stage.
module fir4_data_chain #(
    parameter int W = 18,
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  logic           src_sel,
    input  logic [W-1:0]   loc_in,
    input  logic [W-1:0]   casc_in,
    output logic [N*W-1:0] taps_o,
    output logic [W-1:0]   tail_o
);
    import fir4_pkg::*;

    logic [W-1:0] head_d;

    // Pick the sample that enters stage 0
    always_comb head_d = (src_sel == SRC_CASCADE) ? casc_in : loc_in;

    for (genvar k = 0; k < N; k++) begin : g_stage
        logic [W-1:0] q;
        logic [W-1:0] nxt;

        if (k == 0) begin : g_head
            assign nxt = head_d;
        end else begin : g_body
            assign nxt = taps_o[(k-1)*W +: W];
        end

        // Hold or shift one stage of the delay line
        always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (adv) q <= nxt;
        end

        assign taps_o[k*W +: W] = q;
    end

    assign tail_o = taps_o[(N-1)*W +: W];

endmodule

// File: rtl/fir4_coef_chain.sv
// Module fir4_coef_chain
// Coefficient store of N registers. Loads all stages at once from a flat bus,
// or shifts a serial value into stage 0 toward stage N-1. A parallel load
// beats a serial step, and the enable freezes the chain.
// Assumes no reset: coefficients survive a filter flush.
module fir4_coef_chain #(
    parameter int W = 18,
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           ld_en,
    input  logic           par_ld,
    input  logic [W-1:0]   ser_in,
    input  logic [N*W-1:0] par_in,
    output logic [N*W-1:0] coef_o
);

    for (genvar k = 0; k < N; k++) begin : g_stage
        logic [W-1:0] q;
        logic [W-1:0] ser_nxt;

        if (k == 0) begin : g_head
            assign ser_nxt = ser_in;
        end else begin : g_body
            assign ser_nxt = coef_o[(k-1)*W +: W];
        end

        // Update one coefficient: parallel load first, then serial step
        always_ff @(posedge clk) begin
            if (ld_en) begin
                if (par_ld) q <= par_in[k*W +: W];
                else        q <= ser_nxt;
            end
        end

        assign coef_o[k*W +: W] = q;
    end

endmodule

// File: rtl/fir4_mac.sv
// Module fir4_mac
// Multiplies each sample tap by its coefficient into a product register,
// then adds the N products into a registered sum. A three-flop valid
// pipeline tags the result of each accepted sample.
// Assumes the caller's sample chain updated on the edge where in_vld was high.
module fir4_mac #(
    parameter int DW = 18,
    parameter int CW = 18,
    parameter int N  = 4,
    parameter int SW = 38
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [N*DW-1:0] taps_i,
    input  logic [N*CW-1:0] coef_i,
    output logic [SW-1:0]   y_o,
    output logic            y_vld_o
);
    localparam int PW = DW + CW;
    localparam int GW = SW - PW;

    logic [N*PW-1:0] prod_bus;
    logic [SW-1:0]   sum_d;
    logic            chain_vld_q;
    logic            prod_vld_q;

    for (genvar k = 0; k < N; k++) begin : g_tap
        logic signed [PW-1:0] a_ext;
        logic signed [PW-1:0] b_ext;
        logic signed [PW-1:0] p_d;
        logic        [PW-1:0] p_q;

        assign a_ext = {{CW{taps_i[k*DW+DW-1]}}, taps_i[k*DW +: DW]};
        assign b_ext = {{DW{coef_i[k*CW+CW-1]}}, coef_i[k*CW +: CW]};
        assign p_d   = a_ext * b_ext;

        // Register this tap's product
        always_ff @(posedge clk) begin
            if (!rst_n) p_q <= '0;
            else        p_q <= p_d;
        end

        assign prod_bus[k*PW +: PW] = p_q;
    end

    // Sign-extend and add all registered products
    always_comb begin
        sum_d = '0;
        for (int k = 0; k < N; k++) begin
            sum_d = sum_d + {{GW{prod_bus[k*PW+PW-1]}}, prod_bus[k*PW +: PW]};
        end
    end

    // Register the sum and step the valid pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_o         <= '0;
            chain_vld_q <= 1'b0;
            prod_vld_q  <= 1'b0;
            y_vld_o     <= 1'b0;
        end else begin
            y_o         <= sum_d;
            chain_vld_q <= in_vld;
            prod_vld_q  <= chain_vld_q;
            y_vld_o     <= prod_vld_q;
        end
    end

endmodule

// File: rtl/fir4_slice.sv
// Module fir4_slice
// Top of the cascadable FIR slice: sample chain, coefficient chain and
// multiply-add datapath. The tail of the sample chain is exported for the
// next slice.
// Assumes a synchronous active-low reset that leaves the coefficients intact.
module fir4_slice #(
    parameter int DATA_W = 18,
    parameter int COEF_W = 18,
    parameter int TAPS   = 4,
    localparam int SUM_W = DATA_W + COEF_W + fir4_pkg::grow_bits(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic [DATA_W-1:0]        smp_in,
    input  logic                     casc_sel,
    input  logic [DATA_W-1:0]        casc_in,
    output logic [DATA_W-1:0]        casc_out,
    input  logic                     coef_ld_en,
    input  logic                     coef_par_ld,
    input  logic [COEF_W-1:0]        coef_ser_in,
    input  logic [TAPS*COEF_W-1:0]   coef_par_in,
    output logic [SUM_W-1:0]         y_out,
    output logic                     y_valid
);

    logic [TAPS*DATA_W-1:0] data_bus;
    logic [TAPS*COEF_W-1:0] coef_bus;

    fir4_data_chain #(.W(DATA_W), .N(TAPS)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (smp_valid),
        .src_sel (casc_sel),
        .loc_in  (smp_in),
        .casc_in (casc_in),
        .taps_o  (data_bus),
        .tail_o  (casc_out)
    );

    fir4_coef_chain #(.W(COEF_W), .N(TAPS)) u_coef (
        .clk    (clk),
        .ld_en  (coef_ld_en),
        .par_ld (coef_par_ld),
        .ser_in (coef_ser_in),
        .par_in (coef_par_in),
        .coef_o (coef_bus)
    );

    fir4_mac #(.DW(DATA_W), .CW(COEF_W), .N(TAPS), .SW(SUM_W)) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (smp_valid),
        .taps_i  (data_bus),
        .coef_i  (coef_bus),
        .y_o     (y_out),
        .y_vld_o (y_valid)
    );

endmodule

// File: rtl/fir4_slice_chk.sv
// Module fir4_slice_chk
// Timing checks for fir4_slice, attached to it with a bind statement.
// Assumes the reset is synchronous and active low.
module fir4_slice_chk #(
    parameter int DATA_W = 18,
    parameter int COEF_W = 18,
    parameter int TAPS   = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   smp_valid,
    input logic [DATA_W-1:0]      smp_in,
    input logic                   casc_sel,
    input logic [DATA_W-1:0]      casc_in,
    input logic [DATA_W-1:0]      casc_out,
    input logic                   coef_ld_en,
    input logic                   coef_par_ld,
    input logic [COEF_W-1:0]      coef_ser_in,
    input logic [TAPS*COEF_W-1:0] coef_par_in,
    input logic                   y_valid,
    input logic [TAPS*DATA_W-1:0] data_bus,
    input logic [TAPS*COEF_W-1:0] coef_bus
);

    logic [1:0] settle_q = '0;
    logic       primed_q = 1'b0;

    // Count edges out of reset, saturating at three
    always_ff @(posedge clk) begin
        if (!rst_n)               settle_q <= '0;
        else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
    end

    // Note once all coefficients have been defined by a parallel load
    always_ff @(posedge clk) begin
        if (coef_ld_en && coef_par_ld) primed_q <= 1'b1;
    end

    assert_head_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> data_bus[DATA_W-1:0] == $past(casc_sel ? casc_in : smp_in));

    assert_tail_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> casc_out == $past(data_bus[(TAPS-1)*DATA_W-1 -: DATA_W]));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(data_bus));

    assert_serial_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_ld_en && !coef_par_ld) |=> coef_bus[COEF_W-1:0] == $past(coef_ser_in));

    assert_parallel_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_ld_en && coef_par_ld) |=> coef_bus == $past(coef_par_in));

    assert_coef_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !coef_ld_en) |=> $stable(coef_bus));

    assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q == 2'd3) |-> (y_valid == $past(smp_valid, 3)));

endmodule

bind fir4_slice fir4_slice_chk #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .TAPS   (TAPS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .smp_in      (smp_in),
    .casc_sel    (casc_sel),
    .casc_in     (casc_in),
    .casc_out    (casc_out),
    .coef_ld_en  (coef_ld_en),
    .coef_par_ld (coef_par_ld),
    .coef_ser_in (coef_ser_in),
    .coef_par_in (coef_par_in),
    .y_valid     (y_valid),
    .data_bus    (data_bus),
    .coef_bus    (coef_bus)
);

// File: tb/fir4_slice_tb_top.sv
// Directed bench for fir4_slice. Inputs are driven and outputs sampled at the
// falling edge. A reference model of both chains is updated from the
// requirements as each cycle is driven.
module fir4_slice_tb_top;
    localparam int DW = 18;
    localparam int CW = 18;
    localparam int NT = 4;
    localparam int SW = 38;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            smp_valid = 1'b0;
    logic [DW-1:0]   smp_in = '0;
    logic            casc_sel = 1'b0;
    logic [DW-1:0]   casc_in = '0;
    logic [DW-1:0]   casc_out;
    logic            coef_ld_en = 1'b0;
    logic            coef_par_ld = 1'b0;
    logic [CW-1:0]   coef_ser_in = '0;
    logic [NT*CW-1:0] coef_par_in = '0;
    logic [SW-1:0]   y_out;
    logic            y_valid;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    longint md[NT] = '{default: 0};
    longint mc[NT] = '{default: 0};
    longint zv[NT] = '{default: 0};

    always #2 clk = ~clk;

    fir4_slice dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_in(smp_in),
        .casc_sel(casc_sel), .casc_in(casc_in), .casc_out(casc_out),
        .coef_ld_en(coef_ld_en), .coef_par_ld(coef_par_ld),
        .coef_ser_in(coef_ser_in), .coef_par_in(coef_par_in),
        .y_out(y_out), .y_valid(y_valid)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint model_sum();
        longint s = 0;
        for (int k = 0; k < NT; k++) s += md[k] * mc[k];
        return s;
    endfunction

    function automatic longint y_now();
        return longint'($signed(y_out));
    endfunction

    function automatic longint tail_now();
        return longint'($signed(casc_out));
    endfunction

    // Drive one cycle, update the model, and return at the next falling edge
    task automatic cyc(input bit sv, input longint smp, input bit sel, input longint cin,
                       input bit ld, input bit par, input longint ser, input longint pv[NT]);
        smp_valid   = sv;
        smp_in      = smp[DW-1:0];
        casc_sel    = sel;
        casc_in     = cin[DW-1:0];
        coef_ld_en  = ld;
        coef_par_ld = par;
        coef_ser_in = ser[CW-1:0];
        for (int k = 0; k < NT; k++) coef_par_in[k*CW +: CW] = pv[k][CW-1:0];
        if (!rst_n) begin
            for (int k = 0; k < NT; k++) md[k] = 0;
        end else if (sv) begin
            for (int k = NT-1; k > 0; k--) md[k] = md[k-1];
            md[0] = sel ? cin : smp;
        end
        if (ld) begin
            if (par) begin
                for (int k = 0; k < NT; k++) mc[k] = pv[k];
            end else begin
                for (int k = NT-1; k > 0; k--) mc[k] = mc[k-1];
                mc[0] = ser;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, zv);
    endtask

    task automatic push(input longint s);
        cyc(1, s, 0, 0, 0, 0, 0, zv);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        check("R1", "y_out in reset", y_now(), 0);
        check("R1", "y_valid in reset", longint'(y_valid), 0);
        check("R1", "casc_out in reset", tail_now(), 0);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_parallel();
        longint pv[NT] = '{1, 2, 3, 4};
        cyc(0, 0, 0, 0, 1, 1, 0, pv);
        push(1);
        idle(2);
        check("R5", "impulse tap0", y_now(), 1);
        for (int k = 1; k < NT; k++) begin
            push(0);
            idle(2);
            check("R8", "impulse walk", y_now(), k + 1);
        end
    endtask

    task automatic t_serial();
        cyc(0, 0, 0, 0, 1, 0, 10, zv);
        cyc(0, 0, 0, 0, 1, 0, 20, zv);
        cyc(0, 0, 0, 0, 1, 0, 30, zv);
        cyc(0, 0, 0, 0, 1, 0, 40, zv);
        idle(2);
        check("R4", "first serial value at tap3", y_now(), 10);
        push(5);
        idle(2);
        check("R4", "last serial value at tap0", y_now(), 200);
        check("R8", "model sum", y_now(), model_sum());
    endtask

    task automatic t_priority();
        longint pv[NT] = '{7, 8, 9, 10};
        cyc(0, 0, 0, 0, 1, 1, 99, pv);
        idle(2);
        check("R6", "parallel beats serial", y_now(), 35);
    endtask

    task automatic t_freeze();
        longint pv[NT] = '{100, 100, 100, 100};
        cyc(0, 0, 0, 0, 0, 1, 55, pv);
        cyc(0, 0, 0, 0, 0, 0, 66, pv);
        cyc(0, 0, 0, 0, 0, 1, 77, pv);
        idle(2);
        check("R7", "coefficients frozen", y_now(), 35);
    endtask

    task automatic t_chain();
        cyc(0, 1234, 0, 0, 0, 0, 0, zv);
        check("R2", "no shift without strobe", tail_now(), 0);
        push(11);
        cyc(0, 999, 0, 0, 0, 0, 0, zv);
        push(12);
        push(13);
        check("R2", "tail after three strobes", tail_now(), 5);
        cyc(0, 888, 0, 0, 0, 0, 0, zv);
        push(14);
        check("R2", "tail after four strobes", tail_now(), 11);
        idle(2);
        check("R8", "sum after chain", y_now(), model_sum());
    endtask

    task automatic t_cascade();
        cyc(1, -3, 1, 777, 0, 0, 0, zv);
        idle(2);
        check("R3", "cascade sample at tap0", y_now(), 777 * 7 + 14 * 8 + 13 * 9 + 12 * 10);
        push(0);
        push(0);
        push(0);
        check("R3", "cascade sample at tail", tail_now(), 777);
    endtask

    task automatic t_latency();
        idle(3);
        push(2);
        check("R9", "valid after E", longint'(y_valid), 0);
        idle(1);
        check("R9", "valid after E+1", longint'(y_valid), 0);
        idle(1);
        check("R9", "valid after E+2", longint'(y_valid), 1);
        check("R9", "result with valid", y_now(), model_sum());
        idle(1);
        check("R9", "valid after E+3", longint'(y_valid), 0);
    endtask

    task automatic t_reset_keep();
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        check("R1", "tail cleared", tail_now(), 0);
        check("R1", "sum cleared", y_now(), 0);
        push(1);
        idle(2);
        check("R10", "coefficient kept", y_now(), 7);
    endtask

    task automatic t_fullscale();
        longint neg[NT] = '{-131072, -131072, -131072, -131072};
        longint pos[NT] = '{131071, 131071, 131071, 131071};
        cyc(0, 0, 0, 0, 1, 1, 0, neg);
        for (int k = 0; k < NT; k++) push(-131072);
        idle(2);
        check("R11", "most negative squared", y_now(), 64'sd68719476736);
        cyc(0, 0, 0, 0, 1, 1, 0, pos);
        idle(2);
        check("R11", "max times min", y_now(), -64'sd68718952448);
    endtask

    initial begin
        idle(1);
        t_reset();
        t_parallel();
        t_serial();
        t_priority();
        t_freeze();
        t_chain();
        t_cascade();
        t_latency();
        t_reset_keep();
        t_fullscale();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule